// File: doc/BRIEF.md
# Byte-Lane Bus Sizing Bridge (32-bit processor to 8-bit device bus)

This block sits between a processor bus that is 32 bits wide and an 8-bit device bus, such as a boot ROM or an 8-bit expansion slot. The processor bus has no address lines for bits 1 and 0. Instead it carries four active-low byte enables, one for each byte lane. The bridge rebuilds the two missing address bits from the lowest enabled lane. While a cycle is open, it asserts the bus-size-8 reply so that the processor breaks wide transfers into a series of single-byte cycles.

A single byte at an address that is not a multiple of four travels on its own lane of the 32-bit bus, not on bits 7..0. The bridge therefore steers data in both directions:
- On a read, the device byte is placed onto the selected lane.
- On a write, the selected lane is routed to the 8-bit port.

The bridge drives four active-low strobes: memory read, memory write, I/O read and I/O write. The strobe is chosen from the processor's memory/IO and write/read cycle qualifiers. A decoder outside the bridge says when an 8-bit region is hit. A device-side ready input, also from outside, decides how long the strobe stays active.

Top module: `bus8_bridge`

## Requirements
- R1: The device address is cpu_addr[19:2] followed by two low bits taken from the lowest asserted byte enable: be_n[0] low gives 00, otherwise be_n[1] low gives 01, otherwise be_n[2] low gives 10, otherwise be_n[3] low gives 11. The address stays constant while a cycle is open.
- R2: A cycle opens on a rising clock edge where ads_n is low, sel8 is high and at least one byte enable is low. The matching strobe is low from the following cycle on. While a cycle is open, ads_n is ignored.
- R3: bs8_n is low exactly while a cycle is open and high otherwise.
- R4: Only one strobe is ever active, and the captured qualifiers choose it:
  - mio=1, wr=0 gives memr_n.
  - mio=1, wr=1 gives memw_n.
  - mio=0, wr=0 gives ior_n.
  - mio=0, wr=1 gives iow_n.
- R5: While a cycle is open and dev_ready is low, the strobe stays active and rdy_n stays high. In a cycle where dev_ready is high, rdy_n is low. The strobe is released at that clock edge. Outside a cycle, rdy_n is high.
- R6: During an open read cycle, cpu_d_oe is high. cpu_d_out carries dev_d_in on bits [8k+7:8k], where k is the lane from R1, and zero on all other lanes. At any other time, cpu_d_oe is low.
- R7: During an open write cycle, dev_d_oe is high and dev_d_out equals cpu_d_in[8k+7:8k]. At any other time, dev_d_oe is low. cpu_d_oe and dev_d_oe are never high together.
- R8: When ads_n is low but sel8 is low, or when all four byte enables are high, no cycle opens. No strobe asserts, bs8_n stays high and dev_addr keeps its previous value.
- R9: After reset, all strobes, rdy_n and bs8_n are high, both output enables are low and dev_addr is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ads_n | input | 1 | Address strobe, active low |
| sel8 | input | 1 | An 8-bit region is decoded for this address |
| mio | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| wr | input | 1 | 1 for a write, 0 for a read |
| be_n | input | 4 | Byte enables, active low, bit k for lane k |
| cpu_addr | input | 18 | Processor address bits 19..2 |
| cpu_d_in | input | 32 | Write data from the processor |
| cpu_d_out | output | 32 | Read data to the processor |
| cpu_d_oe | output | 1 | Drive enable for cpu_d_out |
| dev_ready | input | 1 | The device completes the cycle |
| rdy_n | output | 1 | Ready to the processor, active low |
| bs8_n | output | 1 | Bus-size-8 reply, active low |
| dev_addr | output | 20 | 8-bit bus address |
| dev_d_in | input | 8 | Read data from the device |
| dev_d_out | output | 8 | Write data to the device |
| dev_d_oe | output | 1 | Drive enable for dev_d_out |
| memr_n | output | 1 | Memory read strobe |
| memw_n | output | 1 | Memory write strobe |
| ior_n | output | 1 | I/O read strobe |
| iow_n | output | 1 | I/O write strobe |

## Verification
The hardest behaviour to reach is a byte-enable pattern with gaps or high bits set, such as 0101, where the lane priority and the data steering have to agree. The stimulus sweeps every one of the fifteen non-idle enable patterns, combined with all four memory/IO and read/write kinds. Each cycle is held open for zero to two wait cycles, and a different byte is placed on every lane, so that a wrong lane shows up as a wrong value. Rejected requests are interleaved between accepted cycles, so the held address can be compared with the last accepted one.

// File: rtl/bus8_pkg.sv
package bus8_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 4;
  localparam int LIDX_W = $clog2(LANES);

  typedef struct packed {
    logic io;
    logic wr;
  } cyc_kind_t;

  // strobe order in the vector: {iow, ior, memw, memr}, active high here
  typedef logic [3:0] strobe_vec_t;

  function automatic logic any_lane(input logic [LANES-1:0] be_n);
    return ~&be_n;
  endfunction

  function automatic logic [LIDX_W-1:0] lowest_lane(input logic [LANES-1:0] be_n);
    logic [LIDX_W-1:0] idx;
    idx = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (!be_n[k]) idx = LIDX_W'(k);
    end
    return idx;
  endfunction

  function automatic strobe_vec_t strobe_of(input logic open_cyc, input cyc_kind_t kind);
    strobe_vec_t s;
    s = '0;
    if (open_cyc) begin
      case ({kind.io, kind.wr})
        2'b00:   s[0] = 1'b1;
        2'b01:   s[1] = 1'b1;
        2'b10:   s[2] = 1'b1;
        default: s[3] = 1'b1;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/bus8_lane_pick.sv
module bus8_lane_pick
  import bus8_pkg::*;
(
  input  logic [LANES-1:0]  be_n,
  output logic              lane_ok,
  output logic [LIDX_W-1:0] lane
);
  always_comb begin
    lane_ok = any_lane(be_n);
    lane    = lowest_lane(be_n);
  end
endmodule

// File: rtl/bus8_cycle_ctrl.sv
module bus8_cycle_ctrl
  import bus8_pkg::*;
#(
  parameter int DEV_AW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ads_n,
  input  logic              sel8,
  input  logic              mio,
  input  logic              wr,
  input  logic              lane_ok,
  input  logic [LIDX_W-1:0] lane_in,
  input  logic [DEV_AW-1:LIDX_W] addr_in,
  input  logic              dev_ready,
  output logic              cyc_start,
  output logic              cyc_open,
  output cyc_kind_t         kind_q,
  output logic [LIDX_W-1:0] lane_q,
  output logic [DEV_AW-1:0] dev_addr,
  output logic              rdy_n,
  output logic              bs8_n,
  output logic              memr_n,
  output logic              memw_n,
  output logic              ior_n,
  output logic              iow_n
);
  logic [DEV_AW-1:LIDX_W] addr_q;
  strobe_vec_t            stb;

  assign cyc_start = !cyc_open && !ads_n && sel8 && lane_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_open <= 1'b0;
      kind_q   <= '0;
      lane_q   <= '0;
      addr_q   <= '0;
    end else if (cyc_start) begin
      cyc_open  <= 1'b1;
      kind_q.io <= !mio;
      kind_q.wr <= wr;
      lane_q    <= lane_in;
      addr_q    <= addr_in;
    end else if (cyc_open && dev_ready) begin
      cyc_open <= 1'b0;
    end
  end

  always_comb begin
    stb      = strobe_of(cyc_open, kind_q);
    memr_n   = !stb[0];
    memw_n   = !stb[1];
    ior_n    = !stb[2];
    iow_n    = !stb[3];
    bs8_n    = !cyc_open;
    rdy_n    = !(cyc_open && dev_ready);
    dev_addr = {addr_q, lane_q};
  end
endmodule

// File: rtl/bus8_data_steer.sv
module bus8_data_steer
  import bus8_pkg::*;
(
  input  logic                    rd_en,
  input  logic                    wr_en,
  input  logic [LIDX_W-1:0]       lane,
  input  logic [LANES*LANE_W-1:0] cpu_d_in,
  input  logic [LANE_W-1:0]       dev_d_in,
  output logic [LANES*LANE_W-1:0] cpu_d_out,
  output logic                    cpu_d_oe,
  output logic [LANE_W-1:0]       dev_d_out,
  output logic                    dev_d_oe
);
  logic [LANE_W-1:0] lane_bytes [LANES];

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign cpu_d_out[g*LANE_W +: LANE_W] =
        (rd_en && lane == LIDX_W'(g)) ? dev_d_in : '0;
      assign lane_bytes[g] = cpu_d_in[g*LANE_W +: LANE_W];
    end
  endgenerate

  always_comb begin
    dev_d_out = wr_en ? lane_bytes[lane] : '0;
    cpu_d_oe  = rd_en;
    dev_d_oe  = wr_en;
  end
endmodule

// File: rtl/bus8_bridge.sv
module bus8_bridge
  import bus8_pkg::*;
#(
  parameter int DEV_AW = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ads_n,
  input  logic                    sel8,
  input  logic                    mio,
  input  logic                    wr,
  input  logic [LANES-1:0]        be_n,
  input  logic [DEV_AW-1:LIDX_W]  cpu_addr,
  input  logic [LANES*LANE_W-1:0] cpu_d_in,
  output logic [LANES*LANE_W-1:0] cpu_d_out,
  output logic                    cpu_d_oe,
  input  logic                    dev_ready,
  output logic                    rdy_n,
  output logic                    bs8_n,
  output logic [DEV_AW-1:0]       dev_addr,
  input  logic [LANE_W-1:0]       dev_d_in,
  output logic [LANE_W-1:0]       dev_d_out,
  output logic                    dev_d_oe,
  output logic                    memr_n,
  output logic                    memw_n,
  output logic                    ior_n,
  output logic                    iow_n
);
  logic              lane_ok;
  logic [LIDX_W-1:0] lane_now;
  logic [LIDX_W-1:0] lane_q;
  logic              cyc_start;
  logic              cyc_open;
  cyc_kind_t         kind_q;
  logic              rd_phase;
  logic              wr_phase;

  bus8_lane_pick u_pick (
    .be_n    (be_n),
    .lane_ok (lane_ok),
    .lane    (lane_now)
  );

  bus8_cycle_ctrl #(.DEV_AW(DEV_AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ads_n     (ads_n),
    .sel8      (sel8),
    .mio       (mio),
    .wr        (wr),
    .lane_ok   (lane_ok),
    .lane_in   (lane_now),
    .addr_in   (cpu_addr),
    .dev_ready (dev_ready),
    .cyc_start (cyc_start),
    .cyc_open  (cyc_open),
    .kind_q    (kind_q),
    .lane_q    (lane_q),
    .dev_addr  (dev_addr),
    .rdy_n     (rdy_n),
    .bs8_n     (bs8_n),
    .memr_n    (memr_n),
    .memw_n    (memw_n),
    .ior_n     (ior_n),
    .iow_n     (iow_n)
  );

  assign rd_phase = cyc_open && !kind_q.wr;
  assign wr_phase = cyc_open && kind_q.wr;

  bus8_data_steer u_steer (
    .rd_en     (rd_phase),
    .wr_en     (wr_phase),
    .lane      (lane_q),
    .cpu_d_in  (cpu_d_in),
    .dev_d_in  (dev_d_in),
    .cpu_d_out (cpu_d_out),
    .cpu_d_oe  (cpu_d_oe),
    .dev_d_out (dev_d_out),
    .dev_d_oe  (dev_d_oe)
  );
endmodule

// File: rtl/bus8_bridge_chk.sv
module bus8_bridge_chk #(
  parameter int DEV_AW = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_start,
  input logic              cyc_open,
  input logic              rdy_n,
  input logic              bs8_n,
  input logic              cpu_d_oe,
  input logic              dev_d_oe,
  input logic [DEV_AW-1:0] dev_addr,
  input logic              memr_n,
  input logic              memw_n,
  input logic              ior_n,
  input logic              iow_n
);
  logic [3:0] stb;
  logic       stb_any;
  assign stb     = {~iow_n, ~ior_n, ~memw_n, ~memr_n};
  assign stb_any = |stb;

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));

  p_strobe_follows_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> stb_any);

  p_release_on_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n |=> !stb_any);

  p_ready_inside_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n |-> stb_any);

  p_size_with_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stb_any |-> !bs8_n);

  p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_d_oe && dev_d_oe));

  p_addr_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_open && !cyc_start && $past(cyc_open)) |-> $stable(dev_addr));
endmodule

bind bus8_bridge bus8_bridge_chk #(.DEV_AW(DEV_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_start (cyc_start),
  .cyc_open  (cyc_open),
  .rdy_n     (rdy_n),
  .bs8_n     (bs8_n),
  .cpu_d_oe  (cpu_d_oe),
  .dev_d_oe  (dev_d_oe),
  .dev_addr  (dev_addr),
  .memr_n    (memr_n),
  .memw_n    (memw_n),
  .ior_n     (ior_n),
  .iow_n     (iow_n)
);

// File: tb/bus8_bridge_tb.sv
module bus8_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ads_n = 1'b1;
  logic        sel8 = 1'b0;
  logic        mio = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  be_n = 4'hF;
  logic [19:2] cpu_addr = '0;
  logic [31:0] cpu_d_in = '0;
  logic [31:0] cpu_d_out;
  logic        cpu_d_oe;
  logic        dev_ready = 1'b0;
  logic        rdy_n;
  logic        bs8_n;
  logic [19:0] dev_addr;
  logic [7:0]  dev_d_in = '0;
  logic [7:0]  dev_d_out;
  logic        dev_d_oe;
  logic        memr_n, memw_n, ior_n, iow_n;

  int checks = 0;
  int fails = 0;
  logic [19:0] last_addr = '0;

  always #5 clk = ~clk;

  bus8_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .sel8(sel8), .mio(mio), .wr(wr),
    .be_n(be_n), .cpu_addr(cpu_addr), .cpu_d_in(cpu_d_in), .cpu_d_out(cpu_d_out),
    .cpu_d_oe(cpu_d_oe), .dev_ready(dev_ready), .rdy_n(rdy_n), .bs8_n(bs8_n),
    .dev_addr(dev_addr), .dev_d_in(dev_d_in), .dev_d_out(dev_d_out),
    .dev_d_oe(dev_d_oe), .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n),
    .iow_n(iow_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Strobe vector {memr_n,memw_n,ior_n,iow_n}; 4'b1111 means idle.
  function automatic logic [3:0] exp_strobes(input logic m, input logic w);
    logic [3:0] v;
    v = 4'b1111;
    v[3 - ((m ? 0 : 2) + (w ? 1 : 0))] = 1'b0;
    return v;
  endfunction

  function automatic int low_lane(input logic [3:0] b);
    for (int k = 0; k < 4; k++) if (!b[k]) return k;
    return 0;
  endfunction

  task automatic settle();
    @(negedge clk); #2;
  endtask

  task automatic run_cycle(input logic [3:0] b, input logic m, input logic w,
                           input logic [19:2] a, input int waits);
    int ln;
    logic [3:0] es;
    logic [7:0] rbyte;
    ln = low_lane(b);
    es = exp_strobes(m, w);
    rbyte = 8'hA0 ^ {b, 2'(ln), m, w};
    ads_n = 1'b0; sel8 = 1'b1; be_n = b; mio = m; wr = w; cpu_addr = a;
    cpu_d_in = 32'h4433_2211 + {24'h0, b, 4'h0};
    dev_d_in = rbyte;
    @(negedge clk);
    ads_n = 1'b1; sel8 = 1'b0;
    #2;
    check("R1", dev_addr, {a, 2'(ln)});
    last_addr = {a, 2'(ln)};
    check("R4", {memr_n, memw_n, ior_n, iow_n}, es);
    check("R3", bs8_n, 1'b0);
    for (int i = 0; i < waits; i++) begin
      check("R5", {rdy_n, memr_n, memw_n, ior_n, iow_n}, {1'b1, es});
      @(negedge clk); #2;
      check("R2", {memr_n, memw_n, ior_n, iow_n}, es);
      check("R1", dev_addr, {a, 2'(ln)});
    end
    dev_ready = 1'b1;
    #1;
    check("R5", rdy_n, 1'b0);
    if (w) begin
      check("R7", {dev_d_oe, cpu_d_oe, dev_d_out}, {2'b10, cpu_d_in[8*ln +: 8]});
    end else begin
      check("R6", {cpu_d_oe, dev_d_oe}, 2'b10);
      check("R6", cpu_d_out, {24'h0, rbyte} << (8*ln));
    end
    @(negedge clk);
    dev_ready = 1'b0;
    #2;
    check("R5", {rdy_n, bs8_n, memr_n, memw_n, ior_n, iow_n}, 6'h3F);
    check("R7", {cpu_d_oe, dev_d_oe}, 2'b00);
  endtask

  task automatic rejected(input logic s, input logic [3:0] b, input logic [19:2] a);
    ads_n = 1'b0; sel8 = s; be_n = b; mio = 1'b1; wr = 1'b0; cpu_addr = a;
    @(negedge clk);
    ads_n = 1'b1; sel8 = 1'b0;
    #2;
    check("R8", {bs8_n, memr_n, memw_n, ior_n, iow_n}, 5'h1F);
    check("R8", dev_addr, last_addr);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #23;
    check("R9", {memr_n, memw_n, ior_n, iow_n, rdy_n, bs8_n, cpu_d_oe, dev_d_oe},
          8'b1111_1100);
    check("R9", dev_addr, 20'h0);
    rst_n = 1'b1;
    settle();
    for (int b = 0; b < 15; b++) begin
      for (int k = 0; k < 4; k++) begin
        run_cycle(4'(b), k[1], k[0], 18'(b * 4099 + k * 771 + 18'h2A5C5), (b + k) % 3);
        if (k == 1) rejected(1'b0, 4'(b), 18'h3FFFF);
        if (k == 3) rejected(1'b1, 4'hF, 18'h15555);
      end
    end
    // ads_n held low through an open cycle must not restart it (R2)
    ads_n = 1'b0; sel8 = 1'b1; be_n = 4'b0111; mio = 1'b0; wr = 1'b1; cpu_addr = 18'h00F0F;
    @(negedge clk); #2;
    check("R2", {memr_n, memw_n, ior_n, iow_n}, 4'b1110);
    be_n = 4'b1110; cpu_addr = 18'h3C3C3;
    @(negedge clk); #2;
    check("R2", dev_addr, {18'h00F0F, 2'b11});
    ads_n = 1'b1; sel8 = 1'b0;
    dev_ready = 1'b1;
    @(negedge clk); dev_ready = 1'b0; #2;
    check("R5", {bs8_n, iow_n}, 2'b11);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule